// File: doc/BRIEF.md
# Sequence-Tagged Stream Packetizer

This block links an external stream producer and consumer to a packet-switched network on chip. It occupies network address zero. Each word accepted on the input stream becomes one network packet. The packet carries a rotating sequence number, the user data, and a destination coordinate. Destinations are handed out in turn to every element except address zero.

Processing elements send their results back to address zero. Because the network may deliver them in any order, the block files each returned payload in a reorder buffer indexed by its sequence number. It streams payloads out only in the original order, and only when the next expected entry has arrived.

The number of packets in flight is capped at the reorder buffer depth. This guarantees that a sequence number is never reused while its slot is still occupied.

Top module: `seq_packetizer`

## Requirements
- R1: After a synchronous active-low reset, `s_tready` is 1, `noc_out_valid` is 0 and `m_tvalid` is 0.
- R2: An injected packet is laid out as {seq, data, y, x}. x occupies bits [XW-1:0], y the next YW bits, the DW data bits follow, and the SW sequence bits are on top.
- R3: Sequence numbers start at 0 after reset. They rise by one for each accepted input word and wrap modulo 2^SW.
- R4: Destinations cycle through the linear indices 1 to XN*YN-1, where index = y*XN + x, starting at 1. Index 0 is never used.
- R5: While `noc_out_ready` is 0, `s_tready` is 0, and neither the sequence number nor the destination advances.
- R6: When 2^SW packets are outstanding (injected but not yet emitted), `s_tready` and `noc_out_valid` are 0 until an output word is taken.
- R7: A returned packet is stored by its sequence number. `m_tvalid` rises only when the next expected sequence number is present, at the earliest one cycle after its arrival. Words are emitted in strict sequence order.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and `m_tdata` stays stable.
- R9: The x and y bits of a returned packet are ignored; only its sequence and data fields are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready |
| s_tdata | input | DW | Input stream data |
| noc_out_valid | output | 1 | Packet offered to the network |
| noc_out_ready | input | 1 | Network accepts the packet |
| noc_out_data | output | SW+DW+YW+XW | Packet {seq, data, y, x} |
| noc_in_valid | input | 1 | Returned packet present; always accepted |
| noc_in_data | input | SW+DW+YW+XW | Returned packet |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | DW | Output stream data |

## Verification
On every cycle, the assertions check four things:
- the in-flight count never exceeds the buffer depth, and a full count blocks input;
- a busy network blocks input;
- no destination of zero is offered;
- no returned packet lands on an occupied slot, and a stalled output word holds steady.

The bench scenarios show the rest:
- the exact packet layout;
- the rotation and wrap of sequence numbers and destinations;
- that an early-arriving later result does not leak out ahead of the one it waits for;
- that the return coordinates have no effect on the output.

// File: rtl/seq_packetizer.sv
module seq_packetizer #(
  parameter int XN = 2,
  parameter int YN = 2,
  parameter int XW = 1,
  parameter int YW = 1,
  parameter int DW = 8,
  parameter int SW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_tvalid,
  output logic                      s_tready,
  input  logic [DW-1:0]             s_tdata,
  output logic                      noc_out_valid,
  input  logic                      noc_out_ready,
  output logic [SW+DW+YW+XW-1:0]    noc_out_data,
  input  logic                      noc_in_valid,
  input  logic [SW+DW+YW+XW-1:0]    noc_in_data,
  output logic                      m_tvalid,
  input  logic                      m_tready,
  output logic [DW-1:0]             m_tdata
);
  localparam int NODES = XN * YN;
  localparam int IW    = (NODES > 2) ? $clog2(NODES) : 1;
  localparam int DEPTH = 1 << SW;
  localparam int CW    = SW + 1;
  localparam int AW    = XW + YW;
  localparam int TW    = SW + DW + AW;

  logic [IW-1:0]  dst_idx;
  logic [SW-1:0]  tx_seq, rd_seq;
  logic [CW-1:0]  inflight;
  logic [DEPTH-1:0] present;
  logic [DW-1:0]  rob [DEPTH];

  logic [XW-1:0]  dst_x;
  logic [YW-1:0]  dst_y;
  logic           full, fire, emit;
  logic [SW-1:0]  in_seq;
  logic [DW-1:0]  in_dat;
  logic [AW-1:0]  unused_in_addr;

  assign dst_x          = XW'(32'(dst_idx) % XN);
  assign dst_y          = YW'(32'(dst_idx) / XN);
  assign full           = (inflight == CW'(DEPTH));
  assign noc_out_valid  = s_tvalid && !full;
  assign s_tready       = noc_out_ready && !full;
  assign noc_out_data   = {tx_seq, s_tdata, dst_y, dst_x};
  assign fire           = s_tvalid && s_tready;

  assign in_seq         = noc_in_data[TW-1 -: SW];
  assign in_dat         = noc_in_data[AW +: DW];
  assign unused_in_addr = noc_in_data[AW-1:0];

  assign m_tvalid       = present[rd_seq];
  assign m_tdata        = rob[rd_seq];
  assign emit           = m_tvalid && m_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_idx  <= IW'(1);
      tx_seq   <= '0;
      rd_seq   <= '0;
      inflight <= '0;
      present  <= '0;
    end else begin
      if (fire) begin
        tx_seq  <= tx_seq + 1'b1;
        dst_idx <= (32'(dst_idx) == NODES - 1) ? IW'(1) : dst_idx + 1'b1;
      end
      if (fire && !emit)      inflight <= inflight + 1'b1;
      else if (!fire && emit) inflight <= inflight - 1'b1;
      if (emit) begin
        present[rd_seq] <= 1'b0;
        rd_seq          <= rd_seq + 1'b1;
      end
      if (noc_in_valid) present[in_seq] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (noc_in_valid) rob[in_seq] <= in_dat;
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(DEPTH));
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == CW'(DEPTH)) |-> (!s_tready && !noc_out_valid));
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !noc_out_ready |-> !s_tready);
  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    noc_out_valid |-> (noc_out_data[AW-1:0] != '0));
  a_r7_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    noc_in_valid |-> !present[in_seq]);
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
endmodule

// File: tb/seq_packetizer_bench.sv
module seq_packetizer_bench;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_tvalid = 1'b0, s_tready;
  logic [7:0] s_tdata = '0;
  logic noc_out_valid, noc_out_ready = 1'b0;
  logic [TW-1:0] noc_out_data;
  logic noc_in_valid = 1'b0;
  logic [TW-1:0] noc_in_data = '0;
  logic m_tvalid, m_tready = 1'b0;
  logic [7:0] m_tdata;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  seq_packetizer u_seq_packetizer (
    .clk(clk), .rst_n(rst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .noc_out_valid(noc_out_valid), .noc_out_ready(noc_out_ready), .noc_out_data(noc_out_data),
    .noc_in_valid(noc_in_valid), .noc_in_data(noc_in_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata)
  );

  localparam logic [7:0] DIN [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F};
  localparam logic [TW-1:0] EXP [4] = '{
    {2'd0, 8'hA5, 1'b0, 1'b1},
    {2'd1, 8'h3C, 1'b1, 1'b0},
    {2'd2, 8'hF0, 1'b1, 1'b1},
    {2'd3, 8'h0F, 1'b0, 1'b1}
  };
  localparam int RET [4] = '{2, 0, 3, 1};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send_back(input int seq, input logic [1:0] addr);
    @(negedge clk);
    noc_in_valid = 1'b1;
    noc_in_data  = {seq[1:0], DIN[seq], addr};
    @(negedge clk);
    noc_in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    noc_out_ready = 1'b1;
    #1;
    check(s_tready == 1'b1, "R1 s_tready", 32'(s_tready), 1);
    check(noc_out_valid == 1'b0, "R1 noc_out_valid", 32'(noc_out_valid), 0);
    check(m_tvalid == 1'b0, "R1 m_tvalid", 32'(m_tvalid), 0);

    // R2 R3 R4: table walk
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = DIN[i];
      #1;
      check(noc_out_valid && s_tready, "R2 valid/ready", {30'd0, noc_out_valid, s_tready}, 3);
      check(noc_out_data == EXP[i], "R2 R3 R4 packet", 32'(noc_out_data), 32'(EXP[i]));
    end

    @(negedge clk);
    s_tdata = 8'h77;
    #1;
    check(!s_tready && !noc_out_valid, "R6 stall at depth", {30'd0, noc_out_valid, s_tready}, 0);
    s_tvalid = 1'b0;

    // R7: out-of-order return, R9 nonzero address
    send_back(RET[0], 2'b11);
    #1;
    check(m_tvalid == 1'b0, "R7 waits for seq 0", 32'(m_tvalid), 0);
    send_back(RET[1], 2'b00);
    #1;
    check(m_tvalid && m_tdata == DIN[0], "R7 head ready", {23'd0, m_tvalid, m_tdata}, {23'd0, 1'b1, DIN[0]});
    repeat (2) @(negedge clk);
    #1;
    check(m_tvalid && m_tdata == DIN[0], "R8 held", {23'd0, m_tvalid, m_tdata}, {23'd0, 1'b1, DIN[0]});
    send_back(RET[2], 2'b01);
    send_back(RET[3], 2'b10);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      m_tready = 1'b1;
      #1;
      check(m_tvalid && m_tdata == DIN[i], "R7 R9 ordered output", {23'd0, m_tvalid, m_tdata}, {23'd0, 1'b1, DIN[i]});
    end
    @(negedge clk);
    m_tready = 1'b0;
    #1;
    check(m_tvalid == 1'b0, "R7 drained", 32'(m_tvalid), 0);

    // R5: network busy
    s_tvalid = 1'b1;
    s_tdata  = 8'h77;
    noc_out_ready = 1'b0;
    #1;
    check(s_tready == 1'b0, "R5 held", 32'(s_tready), 0);
    @(negedge clk);
    noc_out_ready = 1'b1;
    #1;
    check(s_tready == 1'b1, "R6 space after drain", 32'(s_tready), 1);
    check(noc_out_data == {2'd0, 8'h77, 1'b1, 1'b0}, "R3 R4 R5 wrap and resume",
          32'(noc_out_data), 32'({2'd0, 8'h77, 1'b1, 1'b0}));
    @(negedge clk);
    s_tvalid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule